// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a register-mapped timer that measures time in units of a programmable number of clock cycles. Software programs a divider value and a limit, then issues a start command. The timer stays busy for divider times limit clock cycles and then drops its busy flag by itself. Software can poll a status register to see when the interval has passed.

A free-running option keeps the timer counting past the limit until software issues a stop command. This makes the block usable as an elapsed-time counter as well as a one-shot delay. Start and stop are separate command bits in one control word, and neither bit is stored.

Access uses a simple synchronous bus with a select, a write enable, an 8-bit word address and 32-bit data in each direction. Read data is combinational from the address.

Top module: `prescale_timer`

## Requirements
- R1: After reset, the status (0x09), divider (0x0a), limit (0x0b) and free-running (0x0c) registers all read 0, so free-running mode is off.
- R2: Writing the control word (0x08) with bit 0 set and bit 1 clear sets the busy flag (status bit 0 reads 1 from the next cycle) and clears both internal counters.
- R3: With free-running mode off, the busy flag stays set for exactly P*L clock edges after the start edge and then clears by itself, where P is the divider and L is the limit.
- R4: A divider or limit value of 0 counts as 1, so that run lasts P*L cycles with the zero replaced by 1. The register still reads back the stored 0.
- R5: With free-running mode on (0x0c bit 0 = 1), the timer does not stop at the limit. Its count keeps rising by one every P cycles.
- R6: A control write with bit 1 set clears the busy flag at the next edge. This applies even when bit 0 is also set, so stop takes priority.
- R7: A start command while busy restarts the count from zero. This holds even in the cycle that would otherwise have completed the run.
- R8: Reading 0x0b while busy returns the count of elapsed divider periods. While idle it returns the programmed limit.
- R9: Writes to 0x0a, 0x0b and 0x0c have no effect while the busy flag is set.
- R10: Read data is 0 when the select is low, during writes, for the control address, and for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus select |
| we | input | 1 | Write enable; a read when low |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |

## Verification
A control write can fall in the same cycle as the timer's own completion edge. The bench provokes this by issuing a start on the exact edge where a one-cycle-divider run of limit 3 would finish, and judges that the busy flag stays set and the count reads zero afterwards. Start and stop also meet in a single control word with both bits set, and the bench expects the timer to be idle afterwards. Every bus cycle is compared against a behavioural model that counts elapsed cycles and applies stop, then start, then completion in that priority order.

// File: rtl/prescale_timer_pkg.sv
package prescale_timer_pkg;
    localparam logic [7:0] ADR_CMD   = 8'h08;
    localparam logic [7:0] ADR_STAT  = 8'h09;
    localparam logic [7:0] ADR_DIV   = 8'h0a;
    localparam logic [7:0] ADR_LIMIT = 8'h0b;
    localparam logic [7:0] ADR_FREE  = 8'h0c;
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_HALT_BIT = 1;
    localparam int FREE_EN_BIT  = 0;
endpackage

// File: rtl/prescale_timer_regs.sv
module prescale_timer_regs
    import prescale_timer_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          running,
    input  logic [DW-1:0] count,
    output logic [DW-1:0] rdata,
    output logic          go,
    output logic          halt,
    output logic [DW-1:0] div,
    output logic [DW-1:0] limit,
    output logic          free_en
);
    typedef struct packed {
        logic [DW-1:0] div;
        logic [DW-1:0] limit;
        logic          free;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr;
    logic cmd_hit;

    always_comb begin
        cfg_d   = cfg_q;
        wr      = cs && we;
        cmd_hit = wr && (addr == AW'(ADR_CMD));
        go      = cmd_hit && wdata[CMD_GO_BIT];
        halt    = cmd_hit && wdata[CMD_HALT_BIT];
        if (wr && !running) begin
            if (addr == AW'(ADR_DIV))   cfg_d.div   = wdata;
            if (addr == AW'(ADR_LIMIT)) cfg_d.limit = wdata;
            if (addr == AW'(ADR_FREE))  cfg_d.free  = wdata[FREE_EN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (cs && !we) begin
            if (addr == AW'(ADR_STAT))  rdata = DW'(running);
            if (addr == AW'(ADR_DIV))   rdata = cfg_q.div;
            if (addr == AW'(ADR_LIMIT)) rdata = running ? count : cfg_q.limit;
            if (addr == AW'(ADR_FREE))  rdata = DW'(cfg_q.free);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign div     = cfg_q.div;
    assign limit   = cfg_q.limit;
    assign free_en = cfg_q.free;
endmodule

// File: rtl/prescale_timer_core.sv
module prescale_timer_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          halt,
    input  logic          free_en,
    input  logic [DW-1:0] div,
    input  logic [DW-1:0] limit,
    output logic          running,
    output logic [DW-1:0] count
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] tick;
        logic [DW-1:0] units;
    } state_t;

    state_t st_d, st_q;
    logic [DW-1:0] div_eff;
    logic [DW-1:0] lim_eff;
    logic          wrap;

    always_comb begin
        st_d    = st_q;
        div_eff = (div   == '0) ? ONE : div;
        lim_eff = (limit == '0) ? ONE : limit;
        wrap    = (st_q.tick == div_eff - ONE);
        if (halt) begin
            st_d.run = 1'b0;
        end else if (go) begin
            st_d.run   = 1'b1;
            st_d.tick  = '0;
            st_d.units = '0;
        end else if (st_q.run) begin
            if (wrap) begin
                st_d.tick  = '0;
                st_d.units = st_q.units + ONE;
                if (!free_en && (st_q.units + ONE == lim_eff)) st_d.run = 1'b0;
            end else begin
                st_d.tick = st_q.tick + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign count   = st_q.units;
endmodule

// File: rtl/prescale_timer.sv
module prescale_timer #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic          go_w;
    logic          halt_w;
    logic          run_w;
    logic          free_w;
    logic [DW-1:0] units_w;
    logic [DW-1:0] div_w;
    logic [DW-1:0] limit_w;

    prescale_timer_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .running (run_w),
        .count   (units_w),
        .rdata   (rdata),
        .go      (go_w),
        .halt    (halt_w),
        .div     (div_w),
        .limit   (limit_w),
        .free_en (free_w)
    );

    prescale_timer_core #(.DW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_w),
        .halt    (halt_w),
        .free_en (free_w),
        .div     (div_w),
        .limit   (limit_w),
        .running (run_w),
        .count   (units_w)
    );
endmodule

// File: rtl/prescale_timer_chk.sv
module prescale_timer_chk
    import prescale_timer_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic          go_bit,
    input logic          halt_bit,
    input logic [DW-1:0] rdata,
    input logic          running,
    input logic [DW-1:0] count,
    input logic [DW-1:0] div,
    input logic [DW-1:0] limit,
    input logic          free_en
);
    logic          cmd_wr;
    logic [DW-1:0] lim_eff;
    assign cmd_wr  = cs && we && (addr == AW'(ADR_CMD));
    assign lim_eff = (limit == '0) ? DW'(1) : limit;

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && halt_bit |=> !running); // R6
    AST_GO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && go_bit && !halt_bit |=> running && (count == '0)); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(div) && $stable(limit) && $stable(free_en)); // R9
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !(cmd_wr && go_bit) |=> !running); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running && !free_en |-> count < lim_eff); // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs || we) |-> rdata == '0); // R10
endmodule

bind prescale_timer prescale_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .we       (we),
    .addr     (addr),
    .go_bit   (wdata[0]),
    .halt_bit (wdata[1]),
    .rdata    (rdata),
    .running  (run_w),
    .count    (units_w),
    .div      (div_w),
    .limit    (limit_w),
    .free_en  (free_w)
);

// File: tb/prescale_timer_tb.sv
module prescale_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    prescale_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_run = 1'b0;
    bit          m_free = 1'b0;
    longint      m_el = 0;
    logic [31:0] m_div = '0;
    logic [31:0] m_lim = '0;

    function automatic longint peff();
        return (m_div == 0) ? 1 : longint'(m_div);
    endfunction

    function automatic longint leff();
        return (m_lim == 0) ? 1 : longint'(m_lim);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h09:   return {31'b0, m_run};
            8'h0a:   return m_div;
            8'h0b:   return m_run ? 32'(m_el / peff()) : m_lim;
            8'h0c:   return {31'b0, m_free};
            default: return 32'h0;
        endcase
    endfunction

    task automatic op(input bit c, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
        logic [31:0] exp;
        bit was_run;
        bit cmd;
        @(negedge clk);
        cs = c; we = w; addr = a; wdata = d;
        #1;
        exp = (c && !w) ? exp_read(a) : 32'h0;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
        end
        @(posedge clk);
        was_run = m_run;
        cmd = c && w && (a == 8'h08);
        if (cmd && d[1]) m_run = 1'b0;
        else if (cmd && d[0]) begin
            m_run = 1'b1;
            m_el = 0;
        end else if (m_run) begin
            m_el++;
            if (!m_free && m_el >= peff() * leff()) m_run = 1'b0;
        end
        if (c && w && !was_run) begin
            if (a == 8'h0a) m_div = d;
            if (a == 8'h0b) m_lim = d;
            if (a == 8'h0c) m_free = d[0];
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        op(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        op(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 control address reads 0
        rd(8'h09, "R1"); rd(8'h0a, "R1"); rd(8'h0b, "R1"); rd(8'h0c, "R1");
        rd(8'h08, "R10");

        // R2, R3, R8: divider 3, limit 4 -> 12 cycles
        wr(8'h0a, 32'd3, "R10"); wr(8'h0b, 32'd4, "R10");
        rd(8'h0a, "R1"); rd(8'h0b, "R8");
        wr(8'h08, 32'h1, "R2");
        for (int i = 0; i < 7; i++) begin
            rd(8'h09, "R3");
            rd(8'h0b, "R8");
        end
        rd(8'h0b, "R8");

        // R4: zero divider and limit act as one
        wr(8'h0a, 32'd0, "R4"); wr(8'h0b, 32'd0, "R4");
        wr(8'h08, 32'h1, "R4");
        rd(8'h09, "R4"); rd(8'h09, "R4"); rd(8'h0a, "R4");

        // R9: configuration frozen while busy
        wr(8'h0a, 32'd2, "R9"); wr(8'h0b, 32'd3, "R9");
        wr(8'h08, 32'h1, "R2");
        wr(8'h0a, 32'd7, "R9"); wr(8'h0b, 32'd9, "R9"); wr(8'h0c, 32'h1, "R9");
        rd(8'h0a, "R9"); rd(8'h0c, "R9");
        for (int i = 0; i < 3; i++) rd(8'h09, "R3");
        rd(8'h0b, "R9");

        // R6: stop, and stop with start in one word
        wr(8'h08, 32'h1, "R2"); rd(8'h09, "R6");
        wr(8'h08, 32'h2, "R6"); rd(8'h09, "R6"); rd(8'h0b, "R6");
        wr(8'h08, 32'h1, "R2"); wr(8'h08, 32'h3, "R6"); rd(8'h09, "R6");

        // R7: restart on the completion edge
        wr(8'h0a, 32'd1, "R7"); wr(8'h0b, 32'd3, "R7");
        wr(8'h08, 32'h1, "R7");
        rd(8'h09, "R7"); rd(8'h09, "R7");
        wr(8'h08, 32'h1, "R7");
        rd(8'h09, "R7"); rd(8'h0b, "R7");
        for (int i = 0; i < 3; i++) rd(8'h09, "R7");

        // R5: free-running, then prescaled free-running
        wr(8'h0c, 32'h1, "R5"); wr(8'h0b, 32'd2, "R5");
        wr(8'h08, 32'h1, "R5");
        for (int i = 0; i < 6; i++) rd(8'h0b, "R5");
        rd(8'h09, "R5");
        wr(8'h08, 32'h2, "R5"); rd(8'h09, "R5"); rd(8'h0c, "R5");
        wr(8'h0a, 32'd2, "R5"); wr(8'h08, 32'h1, "R5");
        for (int i = 0; i < 7; i++) rd(8'h0b, "R5");
        wr(8'h08, 32'h2, "R5"); rd(8'h09, "R5");

        // R10: bus idle, unmapped address
        op(1'b0, 1'b0, 8'h09, 32'h0, "R10");
        rd(8'h20, "R10"); wr(8'h20, 32'hffff_ffff, "R10"); rd(8'h0a, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule